// File: doc/BRIEF.md
# Folded Column Filter Stage for a Two-Dimensional Wavelet Transform

This block is the vertical half of a separable 2-D wavelet decomposition. A horizontal stage ahead of it delivers two streams, one low-band and one high-band, as one pair of samples per column position in raster order. For each stream the block runs a 4-tap low-pass and a 4-tap high-pass filter down the columns. It keeps only every second row, and so yields the four subbands: from the low-band stream the low/low and low/high coefficients, from the high-band stream the high/low and high/high coefficients.

Each tap needs the sample from the same column in an earlier row, so every tap position past the first is backed by a circular row buffer. The usable length of the buffer is chosen per decomposition level by a select input: the full width for the first level, then half, then a quarter, and so on. One set of four multipliers per stream is shared between the two coefficient sets. The low-pass result is formed in the cycle after a sample is taken and the high-pass result in the cycle after that. The input therefore accepts at most one sample every two cycles, which is the rate of a polyphase horizontal stage. A clear input starts a new level so that rows from the previous level never reach an output.

Top module: `dwt_col_fold`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` and `out_hi` are 0 after that edge and both result outputs are 0.
- R2: The row length is `MAX_LEN >> lvl_sel`. After that many accepted samples the column position returns to 0 and the row index goes up by one. `lvl_sel` is changed only together with `clr`.
- R3: For row index r and column c, the low-pass result is a0*x(r,c)+a1*x(r-1,c)+a2*x(r-2,c)+a3*x(r-3,c) and the high-pass result uses b0..b3 the same way. It is computed at full precision, with signed inputs and signed outputs.
- R4: A result pair comes out on two consecutive cycles. The low-pass result is visible from the second clock edge after the accepting edge, with `out_hi`=0. The high-pass result follows one edge later, with `out_hi`=1.
- R5: Results appear only for samples whose row index, counted from 0 since the last reset or clear, is odd and at least 3. Each such row yields exactly one pair per column.
- R6: `lx_out` carries the result from the low-band stream `l_in` (low/low, then low/high). `hx_out` carries the result from the high-band stream `h_in` (high/low, then high/high). The two streams are filtered independently.
- R7: A sample presented with `in_valid` in the cycle right after an accepted sample is ignored. It changes no result and no row buffer.
- R8: `clr` returns the column position and row index to 0 and cancels a result pair that is still pending. No sample taken before the clear contributes to any result after it.
- R9: `out_hi`=1 with `out_valid` is always preceded, on the previous cycle, by `out_valid` with `out_hi`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Start a new level: restart the position counters and drop pending results |
| lvl_sel | input | SEL_W | Level select; row length is MAX_LEN >> lvl_sel |
| in_valid | input | 1 | A sample pair is presented on l_in and h_in |
| l_in | input | DATA_W | Signed low-band sample from the horizontal stage |
| h_in | input | DATA_W | Signed high-band sample from the horizontal stage |
| out_valid | output | 1 | A result is present on lx_out and hx_out |
| out_hi | output | 1 | 0: low-pass column result, 1: high-pass column result |
| lx_out | output | OUT_W | Signed result from the low-band stream |
| hx_out | output | OUT_W | Signed result from the high-band stream |

## Verification
The embedded checks take for granted that `lvl_sel` moves only in a cycle where `clr` is high. They also take for granted that the select never names a level beyond the last one, so the column counter always stays inside the selected row length. The stimulus keeps to this: every level change in the bench is driven together with a one-cycle clear, and only the legal select values 0 to 2 are used. The one rule the block itself enforces, dropping a sample offered during the low-pass cycle, is exercised on purpose. It is shown to have no effect through the filtered values of later rows.

// File: rtl/colfold_pkg.sv
// Shared definitions for the folded column filter.
// Assumes: nothing beyond the standard language.
package colfold_pkg;

    // Phase of the shared arithmetic path.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } fold_phase_e;

    // Number of vertical taps per filter.
    localparam int NTAPS = 4;

    // Index width that is at least one bit.
    function automatic int clog2_min1(input int v);
        return (v <= 2) ? 1 : $clog2(v);
    endfunction

endpackage

// File: rtl/colfold_ctrl.sv
// Scan controller: tracks column position and row index within the
// current level, decides when a sample is taken, and sequences the
// low-pass / high-pass phases of the shared arithmetic path.
// Assumes: lvl_sel changes only together with clr; lvl_sel < LEVELS.
module colfold_ctrl
    import colfold_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int LEVELS  = 3,
    localparam int ADDR_W = clog2_min1(MAX_LEN),
    localparam int SEL_W  = clog2_min1(LEVELS),
    localparam int LEN_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              in_valid,
    input  logic [SEL_W-1:0]  lvl_sel,
    output logic              accept,
    output logic [ADDR_W-1:0] col,
    output fold_phase_e       phase,
    output logic              emit
);

    logic [ADDR_W-1:0] col_q;
    logic [1:0]        rows_q;   // completed rows, saturating at 3
    logic              odd_q;    // parity of current row index
    fold_phase_e       phase_q;
    logic              emit_q;
    logic [LEN_W-1:0]  cur_len;
    logic              last_col;

    // Selected row length and end-of-row detection.
    always_comb begin
        cur_len  = LEN_W'(MAX_LEN) >> lvl_sel;
        last_col = ({1'b0, col_q} == (cur_len - LEN_W'(1)));
    end

    // A sample is taken unless the path is in its low-pass cycle or clearing.
    assign accept = in_valid && (phase_q != PH_LOW) && !clr;

    // Position, row and phase bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q   <= '0;
            rows_q  <= '0;
            odd_q   <= 1'b0;
            phase_q <= PH_IDLE;
            emit_q  <= 1'b0;
        end else if (clr) begin
            col_q   <= '0;
            rows_q  <= '0;
            odd_q   <= 1'b0;
            phase_q <= PH_IDLE;
            emit_q  <= 1'b0;
        end else begin
            if (accept) begin
                emit_q  <= odd_q && (rows_q == 2'd3);
                phase_q <= PH_LOW;
                if (last_col) begin
                    col_q <= '0;
                    odd_q <= ~odd_q;
                    if (rows_q != 2'd3) rows_q <= rows_q + 2'd1;
                end else begin
                    col_q <= col_q + ADDR_W'(1);
                end
            end else if (phase_q == PH_LOW) begin
                phase_q <= PH_HIGH;
            end else begin
                phase_q <= PH_IDLE;
            end
        end
    end

    assign col   = col_q;
    assign phase = phase_q;
    assign emit  = emit_q;

    // R2: column position stays inside the selected row length.
    assert_col_in_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, col_q} < cur_len));

    // R2: the last column of a row wraps back to column zero.
    assert_row_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && last_col) |=> (col_q == '0));

    // R2: input assumption, level select moves only with a clear.
    assert_sel_with_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> $stable(lvl_sel));

    // R8: a clear leaves the scan at the row start with nothing pending.
    assert_clear_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((col_q == '0) && (phase_q == PH_IDLE) && !emit_q));

    // R7: no sample is taken in the cycle after one was taken.
    assert_no_back_to_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);

endmodule

// File: rtl/colfold_linebuf.sv
// One row of history for one tap position: a circular store indexed by
// the column position; read is combinational, write is on the clock.
// Assumes: addr < DEPTH; contents are meaningful only once written in
// the current level (the controller masks older rows).
module colfold_linebuf #(
    parameter int DATA_W = 10,
    parameter int DEPTH  = 16,
    localparam int ADDR_W = (DEPTH <= 2) ? 1 : $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Store the new row sample at the current column.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // Older row sample at the current column, seen before the write.
    assign rdata = mem[addr];

endmodule

// File: rtl/colfold_mac.sv
// Folded 4-tap column filter for one stream: holds the four row samples
// of one column and forms either the low-pass or the high-pass sum with a
// single set of four multipliers.
// Assumes: load pulses when a sample is taken; use_hi picks the set.
module colfold_mac
    import colfold_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int COEF_W = 6,
    parameter int LP_C0  = 1,
    parameter int LP_C1  = 3,
    parameter int LP_C2  = 3,
    parameter int LP_C3  = 1,
    parameter int HP_C0  = 1,
    parameter int HP_C1  = -3,
    parameter int HP_C2  = 3,
    parameter int HP_C3  = -1,
    localparam int PROD_W = DATA_W + COEF_W,
    localparam int OUT_W  = PROD_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [NTAPS*DATA_W-1:0] taps_in,
    input  logic                    use_hi,
    output logic signed [OUT_W-1:0] sum
);

    localparam logic signed [COEF_W-1:0] LPV [NTAPS] =
        '{COEF_W'(LP_C0), COEF_W'(LP_C1), COEF_W'(LP_C2), COEF_W'(LP_C3)};
    localparam logic signed [COEF_W-1:0] HPV [NTAPS] =
        '{COEF_W'(HP_C0), COEF_W'(HP_C1), COEF_W'(HP_C2), COEF_W'(HP_C3)};

    logic signed [DATA_W-1:0] tap_q [NTAPS];
    logic signed [PROD_W-1:0] prod  [NTAPS];

    // Capture the column's four row samples when a sample is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NTAPS; k++) tap_q[k] <= '0;
        end else if (load) begin
            for (int k = 0; k < NTAPS; k++)
                tap_q[k] <= taps_in[k*DATA_W +: DATA_W];
        end
    end

    // One shared multiplier per tap, coefficient chosen by phase.
    for (genvar k = 0; k < NTAPS; k++) begin : g_mul
        logic signed [COEF_W-1:0] coef;
        assign coef    = use_hi ? HPV[k] : LPV[k];
        assign prod[k] = PROD_W'(coef) * PROD_W'(tap_q[k]);
    end

    // Adder tree over the four products.
    always_comb begin
        sum = '0;
        for (int k = 0; k < NTAPS; k++) sum = sum + OUT_W'(prod[k]);
    end

endmodule

// File: rtl/dwt_col_fold.sv
// Column stage of a 2-D wavelet decomposition. Two raster-order streams
// from the row stage each pass through three row buffers and a folded
// 4-tap filter; results are kept on odd rows from row 3 on.
// Assumes: in_valid is offered at most every other cycle for full use
// (an offer in the low-pass cycle is dropped); lvl_sel moves with clr.
module dwt_col_fold
    import colfold_pkg::*;
#(
    parameter int DATA_W  = 10,
    parameter int COEF_W  = 6,
    parameter int MAX_LEN = 16,
    parameter int LEVELS  = 3,
    parameter int LP_C0   = 1,
    parameter int LP_C1   = 3,
    parameter int LP_C2   = 3,
    parameter int LP_C3   = 1,
    parameter int HP_C0   = 1,
    parameter int HP_C1   = -3,
    parameter int HP_C2   = 3,
    parameter int HP_C3   = -1,
    localparam int SEL_W  = clog2_min1(LEVELS),
    localparam int ADDR_W = clog2_min1(MAX_LEN),
    localparam int OUT_W  = DATA_W + COEF_W + 2,
    localparam int NBR    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [SEL_W-1:0]  lvl_sel,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] l_in,
    input  logic [DATA_W-1:0] h_in,
    output logic              out_valid,
    output logic              out_hi,
    output logic [OUT_W-1:0]  lx_out,
    output logic [OUT_W-1:0]  hx_out
);

    logic              acc;
    logic [ADDR_W-1:0] col;
    fold_phase_e       phase;
    logic              emit;
    logic              fire;
    logic              hi_now;
    logic signed [OUT_W-1:0] sums [NBR];

    colfold_ctrl #(
        .MAX_LEN (MAX_LEN),
        .LEVELS  (LEVELS)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .in_valid (in_valid),
        .lvl_sel  (lvl_sel),
        .accept   (acc),
        .col      (col),
        .phase    (phase),
        .emit     (emit)
    );

    assign hi_now = (phase == PH_HIGH);
    assign fire   = emit && !clr && ((phase == PH_LOW) || hi_now);

    // One row-buffer chain and one folded filter per input stream.
    for (genvar b = 0; b < NBR; b++) begin : g_br
        logic [DATA_W-1:0]       x_new;
        logic [DATA_W-1:0]       hist [NTAPS];
        logic [NTAPS*DATA_W-1:0] taps;

        assign x_new   = (b == 0) ? l_in : h_in;
        assign hist[0] = x_new;

        for (genvar k = 1; k < NTAPS; k++) begin : g_row
            colfold_linebuf #(
                .DATA_W (DATA_W),
                .DEPTH  (MAX_LEN)
            ) u_line (
                .clk   (clk),
                .we    (acc),
                .addr  (col),
                .wdata (hist[k-1]),
                .rdata (hist[k])
            );
        end

        for (genvar k = 0; k < NTAPS; k++) begin : g_pack
            assign taps[k*DATA_W +: DATA_W] = hist[k];
        end

        colfold_mac #(
            .DATA_W (DATA_W), .COEF_W (COEF_W),
            .LP_C0 (LP_C0), .LP_C1 (LP_C1), .LP_C2 (LP_C2), .LP_C3 (LP_C3),
            .HP_C0 (HP_C0), .HP_C1 (HP_C1), .HP_C2 (HP_C2), .HP_C3 (HP_C3)
        ) u_mac (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (acc),
            .taps_in (taps),
            .use_hi  (hi_now),
            .sum     (sums[b])
        );
    end

    // Register the kept results; data holds between kept results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_hi    <= 1'b0;
            lx_out    <= '0;
            hx_out    <= '0;
        end else begin
            out_valid <= fire;
            out_hi    <= fire && hi_now;
            if (fire) begin
                lx_out <= sums[0];
                hx_out <= sums[1];
            end
        end
    end

    // R1: reset leaves the result port quiet.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_hi));

    // R9: a high-pass result always follows a low-pass result.
    assert_hi_after_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_hi) |-> $past(out_valid && !out_hi));

    // R4: a low-pass result is followed by its high-pass partner.
    assert_pair_complete_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hi && !clr) |=> (out_valid && out_hi));

    // R4: a low-pass result appears two edges after the sample was taken.
    assert_lo_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hi) |-> $past(acc, 2));

endmodule

// File: tb/sim_dwt_col_fold.sv
module sim_dwt_col_fold;

    localparam int DW   = 10;
    localparam int OW   = 18;
    localparam int MAXL = 16;
    localparam int A0 = 1, A1 = 3, A2 = 3, A3 = 1;
    localparam int B0 = 1, B1 = -3, B2 = 3, B3 = -1;

    // sel, rows, row mult, col mult, offset, idle gap, junk offer
    localparam int NV = 6;
    localparam int TBL [NV][7] = '{
        '{0, 6,  7,  3, 11, 0, 0},
        '{1, 8, 13,  5,  2, 0, 0},
        '{2, 9, 29, 17, 40, 2, 0},
        '{2, 7,  5, 31,  3, 0, 1},
        '{1, 5, 91,  1, 77, 1, 1},
        '{0, 4,  3, 97,  5, 0, 0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic [1:0]    lvl_sel = 2'd0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] l_in = '0;
    logic [DW-1:0] h_in = '0;
    logic          out_valid;
    logic          out_hi;
    logic [OW-1:0] lx_out;
    logic [OW-1:0] hx_out;

    always #5 clk = ~clk;

    dwt_col_fold #(
        .DATA_W (DW), .COEF_W (6), .MAX_LEN (MAXL), .LEVELS (3),
        .LP_C0 (A0), .LP_C1 (A1), .LP_C2 (A2), .LP_C3 (A3),
        .HP_C0 (B0), .HP_C1 (B1), .HP_C2 (B2), .HP_C3 (B3)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .clr (clr), .lvl_sel (lvl_sel),
        .in_valid (in_valid), .l_in (l_in), .h_in (h_in),
        .out_valid (out_valid), .out_hi (out_hi),
        .lx_out (lx_out), .hx_out (hx_out)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    int hist [2][3][MAXL];
    int m_col, m_row, m_len;
    int e_lo [2][1024];
    int e_hi [2][1024];
    int wr = 0, rd = 0;
    int n_lo = 0;
    string tag = "R3";

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int px(input int v, input int m);
        return ((v % m) + m) % m - m / 2;
    endfunction

    task automatic model_clear(input int sel);
        m_col = 0;
        m_row = 0;
        m_len = MAXL >> sel;
        for (int b = 0; b < 2; b++)
            for (int k = 0; k < 3; k++)
                for (int c = 0; c < MAXL; c++) hist[b][k][c] = 0;
    endtask

    // Model one accepted sample: compute results if the row is kept.
    task automatic model_push(input int pl, input int ph);
        for (int b = 0; b < 2; b++) begin
            int x0;
            x0 = (b == 0) ? pl : ph;
            if ((m_row % 2 == 1) && (m_row >= 3)) begin
                e_lo[b][wr] = A0*x0 + A1*hist[b][0][m_col] + A2*hist[b][1][m_col] + A3*hist[b][2][m_col];
                e_hi[b][wr] = B0*x0 + B1*hist[b][0][m_col] + B2*hist[b][1][m_col] + B3*hist[b][2][m_col];
            end
            hist[b][2][m_col] = hist[b][1][m_col];
            hist[b][1][m_col] = hist[b][0][m_col];
            hist[b][0][m_col] = x0;
        end
        if ((m_row % 2 == 1) && (m_row >= 3)) wr++;
        if (m_col == m_len - 1) begin
            m_col = 0;
            m_row++;
        end else begin
            m_col++;
        end
    endtask

    // Offer one sample; optionally offer junk in the low-pass cycle (R7).
    task automatic feed(input int pl, input int ph, input bit junk, input int gap);
        @(negedge clk);
        in_valid = 1'b1;
        l_in = DW'(pl);
        h_in = DW'(ph);
        model_push(pl, ph);
        @(negedge clk);
        if (junk) begin
            l_in = DW'(pl + 123);
            h_in = DW'(ph - 77);
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic pulse_clear(input int sel);
        @(negedge clk);
        clr = 1'b1;
        lvl_sel = 2'(sel);
        model_clear(sel);
        @(negedge clk);
        clr = 1'b0;
    endtask

    // Compare every kept result against the model (R3, R4, R6, R9).
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (rd >= wr) begin
                check(1'b0, "R5 unexpected result", int'($signed(lx_out)), 0);
            end else if (!out_hi) begin
                n_lo++;
                check(int'($signed(lx_out)) == e_lo[0][rd], {tag, " R6 low-band low-pass"}, int'($signed(lx_out)), e_lo[0][rd]);
                check(int'($signed(hx_out)) == e_lo[1][rd], {tag, " R6 high-band low-pass"}, int'($signed(hx_out)), e_lo[1][rd]);
            end else begin
                check(int'($signed(lx_out)) == e_hi[0][rd], {tag, " R4 low-band high-pass"}, int'($signed(lx_out)), e_hi[0][rd]);
                check(int'($signed(hx_out)) == e_hi[1][rd], {tag, " R4 high-band high-pass"}, int'($signed(hx_out)), e_hi[1][rd]);
                rd++;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        int kept;
        model_clear(0);
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        check(out_hi == 1'b0, "R1 out_hi in reset", int'(out_hi), 0);
        check(lx_out == '0, "R1 lx_out in reset", int'(lx_out), 0);
        check(hx_out == '0, "R1 hx_out in reset", int'(hx_out), 0);
        rst_n = 1'b1;

        // Table walk: level select R2, decimation R5, ignored offers R7
        for (int v = 0; v < NV; v++) begin
            int sel, rows, len;
            sel  = TBL[v][0];
            rows = TBL[v][1];
            len  = MAXL >> sel;
            tag  = (TBL[v][6] != 0) ? "R7 R3" : "R2 R3";
            pulse_clear(sel);
            base = n_lo;
            for (int r = 0; r < rows; r++)
                for (int c = 0; c < len; c++)
                    feed(px(r*TBL[v][2] + c*TBL[v][3] + TBL[v][4], 401),
                         px(r*TBL[v][3] - c*TBL[v][2] + 3*TBL[v][4], 301),
                         TBL[v][6] != 0, TBL[v][5]);
            repeat (4) @(negedge clk);
            kept = 0;
            for (int r = 3; r < rows; r++) if (r % 2 == 1) kept += len;
            check(n_lo - base == kept, "R5 kept result count", n_lo - base, kept);
            check(rd == wr, "R2 all expected results seen", rd, wr);
        end

        // R8: clear cancels a pending pair and discards earlier rows
        tag = "R8";
        pulse_clear(2);
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 4; c++) feed(px(r*50 + c*9, 391), px(c*40 - r, 201), 1'b0, 0);
        @(negedge clk);
        in_valid = 1'b1;
        l_in = DW'(99);
        h_in = DW'(-42);
        @(negedge clk);
        in_valid = 1'b0;
        clr = 1'b1;
        lvl_sel = 2'd2;
        model_clear(2);
        @(negedge clk);
        clr = 1'b0;
        base = n_lo;
        repeat (4) @(negedge clk);
        check(n_lo == base, "R8 pending pair cancelled", n_lo - base, 0);
        check(rd == wr, "R8 nothing extra after clear", wr - rd, 0);
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++) feed(px(r*17 + c*61, 333), px(r*3 + c*5, 111), 1'b0, 0);
        repeat (4) @(negedge clk);
        check(n_lo - base == 4, "R8 fresh level count", n_lo - base, 4);
        check(rd == wr, "R8 fresh level values", rd, wr);

        // R1: reset in the middle of a pending pair
        tag = "R1";
        pulse_clear(2);
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 4; c++) feed(r + c, c - r, 1'b0, 0);
        @(negedge clk);
        in_valid = 1'b1;
        l_in = DW'(5);
        h_in = DW'(6);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after mid-run reset", int'(out_valid), 0);
        check(lx_out == '0, "R1 lx_out after mid-run reset", int'(lx_out), 0);
        check(hx_out == '0, "R1 hx_out after mid-run reset", int'(hx_out), 0);
        rst_n = 1'b1;
        model_clear(2);
        base = n_lo;
        repeat (4) @(negedge clk);
        check(n_lo == base, "R1 no result after reset", n_lo - base, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule